// File: doc/BRIEF.md
# Polled Vectored Interrupt Requester

This block is the interrupt side of a bus card that shares a priority-chained processor bus. A local interrupt event raises a pending flag. The flag is raised only if software has enabled the mask, or if the event comes from the unmaskable sync source. The processor polls every card with a strobe. A card with a pending flag latches an interrupt flop and answers with a one-cycle pulse on one of three level lines, which a static select input picks.

If the processor decides to serve the card, it pulls its active-low enable line low. The block then acts as its own bus grant cell. It breaks the daisy-chained grant to lower-priority cards, and it takes bus control once the incoming grant is present and no other card holds the bus. While it holds control, it drives a trap address looked up from the number of the source that raised the flag. One clock after taking control it drops an active-low address-valid strobe. When the processor releases the enable line, the request and control flops clear and the cycle ends. An event that arrives during service stays pending and is posted at the next poll.

Top module: `irq_vec_requester`

## Requirements
- R1: An event is accepted (sets the pending flag) only when `mask_en` is 1 or `evt_sync` is 1; an event with both 0 is ignored and a later poll gives no level pulse.
- R2: A poll (`poll`=1 at a clock edge) while the flag is pending and no bus request or bus control is held makes `lvl_pulse` show the selected line for exactly the cycle after that edge. A poll with no flag pending, or during a bus request or service, gives `lvl_pulse`=0.
- R3: `lvl_sel`=0 selects `lvl_pulse` bit 0 (level 5), 1 selects bit 1 (level 6), and 2 or 3 select bit 2 (level 7, the highest). At most one bit is ever set.
- R4: `grant_out` equals `grant_in` except while the bus request flop is set, when it is 0. The request flop sets on the edge after the interrupt flop is set with `ien_n`=0.
- R5: Bus control sets on an edge where the request flop is set, `grant_in`=1, `bus_busy_in`=0 and `ien_n`=0. `bus_busy_out` shows bus control. `trap_addr` is driven only during bus control and is 0 otherwise.
- R6: `iadv_n` goes to 0 on the first edge after bus control sets and stays 0 until teardown.
- R7: An edge with `ien_n`=1 clears the request flop, bus control and `iadv_n` (back to 1). A request abandoned this way leaves the flag and the interrupt flop set, so the next poll pulses again.
- R8: On the edge after bus control sets, the request flop, the interrupt flop and the pending flag all clear. A later poll with no new event gives no pulse.
- R9: `trap_addr` = TRAP_BASE + source × TRAP_STRIDE (defaults 0x40 and 4, 8-bit), taken from the source number latched with the pending flag.
- R10: An event accepted while the card is in service, including in the very cycle the flag clears, leaves the flag pending with the new source. It does not alter the trap address being served, and it is posted at the next poll.
- R11: While a flag is pending, later events do not change the latched source.
- R12: During reset, `lvl_pulse`=0, `bus_busy_out`=0, `trap_addr`=0, `iadv_n`=1 and `grant_out`=`grant_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Interrupt event strobe |
| evt_sync | input | 1 | Event is from the unmaskable sync source |
| evt_src | input | SRC_W | Source number of the event |
| mask_en | input | 1 | Interrupt mask enable |
| lvl_sel | input | 2 | Static level select |
| poll | input | 1 | Processor poll strobe |
| ien_n | input | 1 | Active-low interrupt enable from processor |
| grant_in | input | 1 | Grant from higher-priority card |
| bus_busy_in | input | 1 | Bus held by another card |
| grant_out | output | 1 | Grant to lower-priority card |
| bus_busy_out | output | 1 | This card holds bus control |
| lvl_pulse | output | 3 | Level lines (bit 2 = level 7) |
| trap_addr | output | ADDR_W | Trap address on the data bus, 0 when not driving |
| iadv_n | output | 1 | Active-low interrupt-address-valid |

## Verification
Two functions can land on the same edge: clearing the pending flag at the start of service, and accepting a new event. The bench raises an event in the first cycle of bus control, so both act at one edge. It then checks that the trap address being served is still the old source's, and that after teardown a poll pulses and a second service delivers the new source's vector. The bench also polls while a request is held but bus control is blocked by a busy bus, and checks that no level pulse appears.

// File: rtl/irq_req_pkg.sv
`timescale 1ns/1ps
// Package: shared level-line width and the jumper decode.
// Assumes three level lines, bit 2 being the highest level.
package irq_req_pkg;
    localparam int unsigned NUM_LVL = 3;
    typedef logic [NUM_LVL-1:0] lvl_vec_t;

    // Map a two-bit jumper select to a one-hot level line; 2 and 3 both pick the top line.
    function automatic lvl_vec_t lvl_decode(input logic [1:0] sel);
        lvl_vec_t v;
        v = '0;
        if (sel >= 2'd2) v[NUM_LVL-1] = 1'b1;
        else             v[sel]       = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/irq_pend_flag.sv
`timescale 1ns/1ps
// Pending-flag holder: accepts masked or sync events and latches the source
// number of the first accepted event. A new event wins over a clear in the same cycle.
// Assumes clr_i is a one-cycle pulse from the level gate.
module irq_pend_flag #(
    parameter int unsigned SRC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid_i,
    input  logic             evt_sync_i,
    input  logic [SRC_W-1:0] evt_src_i,
    input  logic             mask_en_i,
    input  logic             clr_i,
    output logic             pend_o,
    output logic [SRC_W-1:0] src_o
);
    logic accept;

    // Event passes the mask unless it is the sync source.
    always_comb accept = evt_valid_i && (mask_en_i || evt_sync_i);

    // Flag and source registers; source reloads only when the flag is free or clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            src_o  <= '0;
        end else begin
            pend_o <= accept || (pend_o && !clr_i);
            if (accept && (!pend_o || clr_i)) src_o <= evt_src_i;
        end
    end

    // R1: nothing sets the flag without an accepted event.
    p_mask_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !(evt_valid_i && (mask_en_i || evt_sync_i))) |=> !pend_o);

    // R11: source held while pending and not clearing.
    p_src_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> $stable(src_o));
endmodule

// File: rtl/irq_level_gate.sv
`timescale 1ns/1ps
// Poll responder: sets the interrupt flop on a poll with a pending flag and
// pulses the jumper-selected level line for one cycle. Clears the flop and
// issues the flag clear on the first edge of bus control.
// Assumes in_svc_i covers both the request and the control flops.
module irq_level_gate
    import irq_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       poll_i,
    input  logic       pend_i,
    input  logic       in_svc_i,
    input  logic       busc_i,
    input  logic [1:0] sel_i,
    output logic       intr_o,
    output lvl_vec_t   lvl_o,
    output logic       clr_o
);
    logic take;

    // A poll is answered only with a pending flag and no service under way.
    always_comb take = poll_i && pend_i && !in_svc_i;

    // Flag clear pulse: bus control is up while the interrupt flop is still set.
    always_comb clr_o = busc_i && intr_o;

    // Interrupt flop and registered level pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intr_o <= 1'b0;
            lvl_o  <= '0;
        end else begin
            intr_o <= !busc_i && (intr_o || take);
            lvl_o  <= take ? lvl_decode(sel_i) : '0;
        end
    end

    // R3: at most one level line.
    p_lvl_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lvl_o));

    // R2: a pulse never lasts two cycles without a second poll.
    p_lvl_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_o != '0) && !poll_i) |=> (lvl_o == '0));

    // R8: interrupt flop drops once bus control is seen.
    p_intr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busc_i |=> !intr_o);
endmodule

// File: rtl/irq_bus_grant.sv
`timescale 1ns/1ps
// Bus grant cell: request flop breaks the grant chain, control flop takes
// the bus when granted and idle. Both clear when the enable line is released.
// Assumes bus_busy_i excludes this card's own control.
module irq_bus_grant (
    input  logic clk,
    input  logic rst_n,
    input  logic intr_i,
    input  logic ien_n_i,
    input  logic grant_in_i,
    input  logic bus_busy_i,
    output logic grab_o,
    output logic busc_o,
    output logic busc_set_o,
    output logic grant_out_o
);
    // Control takes the bus on this edge.
    always_comb busc_set_o = grab_o && grant_in_i && !bus_busy_i && !ien_n_i && !busc_o;

    // Chain passes grant unless this card requests.
    always_comb grant_out_o = grant_in_i && !grab_o;

    // Request and control flops with enable-driven teardown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grab_o <= 1'b0;
            busc_o <= 1'b0;
        end else begin
            grab_o <= !ien_n_i && !busc_o && (grab_o || intr_i);
            busc_o <= !ien_n_i && (busc_o || busc_set_o);
        end
    end

    // R7: enable released tears both flops down.
    p_teardown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ien_n_i |=> (!grab_o && !busc_o));

    // R5: control only rises from a granted, idle bus.
    p_busc_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busc_o) |-> ($past(grant_in_i) && !$past(bus_busy_i) && $past(grab_o)));
endmodule

// File: rtl/irq_trap_vector.sv
`timescale 1ns/1ps
// Trap vector driver: computes base + source * stride, captures it when bus
// control sets, drives it only under control, and raises address-valid
// (active low) one clock after control.
// Assumes busc_set_i is a one-cycle pulse on the edge control sets.
module irq_trap_vector #(
    parameter int unsigned              SRC_W       = 3,
    parameter int unsigned              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0]        TRAP_BASE   = 'h40,
    parameter logic [ADDR_W-1:0]        TRAP_STRIDE = 'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_i,
    input  logic              busc_set_i,
    input  logic              busc_i,
    input  logic              ien_n_i,
    output logic [ADDR_W-1:0] trap_o,
    output logic              iadv_n_o
);
    logic [ADDR_W-1:0] calc;
    logic [ADDR_W-1:0] trap_q;

    // Vector lookup computed from the source number.
    always_comb calc = TRAP_BASE + ADDR_W'(src_i) * TRAP_STRIDE;

    // Vector capture and address-valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q   <= '0;
            iadv_n_o <= 1'b1;
        end else begin
            if (busc_set_i) trap_q <= calc;
            iadv_n_o <= !(busc_i && !ien_n_i);
        end
    end

    // Data bus drive only under control.
    always_comb trap_o = busc_i ? trap_q : '0;

    // R6: strobe follows control by one clock.
    p_iadv_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busc_i && !ien_n_i) |=> !iadv_n_o);

    // R10: vector steady through service.
    p_vec_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busc_i && !ien_n_i) |=> $stable(trap_q));
endmodule

// File: rtl/irq_vec_requester.sv
`timescale 1ns/1ps
// Top: polled vectored interrupt requester with its own bus grant cell.
// Wires flag, poll responder, grant cell and vector driver.
// Assumes lvl_sel is static and poll is a one-cycle strobe.
module irq_vec_requester
    import irq_req_pkg::*;
#(
    parameter int unsigned       SRC_W       = 3,
    parameter int unsigned       ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] TRAP_BASE   = 'h40,
    parameter logic [ADDR_W-1:0] TRAP_STRIDE = 'h4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic               evt_sync,
    input  logic [SRC_W-1:0]   evt_src,
    input  logic               mask_en,
    input  logic [1:0]         lvl_sel,
    input  logic               poll,
    input  logic               ien_n,
    input  logic               grant_in,
    input  logic               bus_busy_in,
    output logic               grant_out,
    output logic               bus_busy_out,
    output logic [NUM_LVL-1:0] lvl_pulse,
    output logic [ADDR_W-1:0]  trap_addr,
    output logic               iadv_n
);
    logic             pend, clr, intr, grab, busc, busc_set, in_svc;
    logic [SRC_W-1:0] src;

    // Service under way: request or control held.
    always_comb in_svc = grab || busc;

    irq_pend_flag #(.SRC_W(SRC_W)) u_flag (
        .clk(clk), .rst_n(rst_n), .evt_valid_i(evt_valid), .evt_sync_i(evt_sync),
        .evt_src_i(evt_src), .mask_en_i(mask_en), .clr_i(clr),
        .pend_o(pend), .src_o(src)
    );

    irq_level_gate u_lvl (
        .clk(clk), .rst_n(rst_n), .poll_i(poll), .pend_i(pend), .in_svc_i(in_svc),
        .busc_i(busc), .sel_i(lvl_sel), .intr_o(intr), .lvl_o(lvl_pulse), .clr_o(clr)
    );

    irq_bus_grant u_gnt (
        .clk(clk), .rst_n(rst_n), .intr_i(intr), .ien_n_i(ien_n),
        .grant_in_i(grant_in), .bus_busy_i(bus_busy_in), .grab_o(grab),
        .busc_o(busc), .busc_set_o(busc_set), .grant_out_o(grant_out)
    );

    irq_trap_vector #(.SRC_W(SRC_W), .ADDR_W(ADDR_W), .TRAP_BASE(TRAP_BASE),
                      .TRAP_STRIDE(TRAP_STRIDE)) u_vec (
        .clk(clk), .rst_n(rst_n), .src_i(src), .busc_set_i(busc_set), .busc_i(busc),
        .ien_n_i(ien_n), .trap_o(trap_addr), .iadv_n_o(iadv_n)
    );

    always_comb bus_busy_out = busc;

    // R4: chain stays broken while requesting.
    p_chain_break_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grab |-> !grant_out);

    // R8: flag cleared on the edge after control sets unless a new event arrives.
    p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt_valid) |=> !pend);
endmodule

// File: tb/sim_irq_vec_requester.sv
`timescale 1ns/1ps
module sim_irq_vec_requester;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 1'b0, evt_sync = 1'b0, mask_en = 1'b0;
    logic [2:0] evt_src = '0;
    logic [1:0] lvl_sel = '0;
    logic       poll = 1'b0, ien_n = 1'b1, grant_in = 1'b1, bus_busy_in = 1'b0;
    logic       grant_out, bus_busy_out, iadv_n;
    logic [2:0] lvl_pulse;
    logic [7:0] trap_addr;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    irq_vec_requester u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_sync(evt_sync),
        .evt_src(evt_src), .mask_en(mask_en), .lvl_sel(lvl_sel), .poll(poll),
        .ien_n(ien_n), .grant_in(grant_in), .bus_busy_in(bus_busy_in),
        .grant_out(grant_out), .bus_busy_out(bus_busy_out), .lvl_pulse(lvl_pulse),
        .trap_addr(trap_addr), .iadv_n(iadv_n)
    );

    // {sel[2], src[3], mask, sync, exp_lvl[3]}
    localparam logic [9:0] VEC [6] = '{
        {2'd0, 3'd1, 1'b1, 1'b0, 3'b001},
        {2'd1, 3'd2, 1'b1, 1'b0, 3'b010},
        {2'd2, 3'd5, 1'b1, 1'b0, 3'b100},
        {2'd3, 3'd7, 1'b1, 1'b0, 3'b100},
        {2'd1, 3'd3, 1'b0, 1'b0, 3'b000},
        {2'd0, 3'd6, 1'b0, 1'b1, 3'b001}
    };

    function automatic logic [7:0] exp_trap(input logic [2:0] s);
        return 8'h40 + 8'(s) * 8'd4;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic post(input logic [2:0] s, input logic m, input logic y);
        evt_valid = 1'b1; evt_src = s; mask_en = m; evt_sync = y;
        tick();
        evt_valid = 1'b0; evt_sync = 1'b0;
    endtask

    task automatic do_poll(output logic [2:0] seen);
        poll = 1'b1;
        tick();
        seen = lvl_pulse;
        poll = 1'b0;
    endtask

    // Full service from a posted interrupt flop; checks R4-R9 along the way.
    task automatic serve(input logic [7:0] tv);
        ien_n = 1'b0;
        tick();
        chk("R4 chain broken by request", grant_out, 0);
        tick();
        chk("R5 busy out under control", bus_busy_out, 1);
        chk("R9 trap address", trap_addr, tv);
        chk("R6 iadv still high first control cycle", iadv_n, 1);
        tick();
        chk("R6 iadv low after control", iadv_n, 0);
        chk("R8 request flop cleared, chain restored", grant_out, 1);
        chk("R9 trap held", trap_addr, tv);
        ien_n = 1'b1;
        tick();
        chk("R7 control cleared", bus_busy_out, 0);
        chk("R7 iadv released", iadv_n, 1);
        chk("R5 trap zero off bus", trap_addr, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [2:0] seen;
        repeat (3) tick();
        // R12 reset state
        chk("R12 lvl in reset", lvl_pulse, 0);
        chk("R12 busy in reset", bus_busy_out, 0);
        chk("R12 trap in reset", trap_addr, 0);
        chk("R12 iadv in reset", iadv_n, 1);
        chk("R12 grant passes in reset", grant_out, 1);
        rst_n = 1'b1;
        tick();

        // Table walk: R1, R2, R3, R9
        for (int i = 0; i < 6; i++) begin
            logic [9:0] v;
            v = VEC[i];
            lvl_sel = v[9:8];
            post(v[7:5], v[4], v[3]);
            do_poll(seen);
            chk("R3 R1 level line on poll", seen, v[2:0]);
            tick();
            chk("R2 pulse lasts one cycle", lvl_pulse, 0);
            if (v[2:0] != 3'b000) begin
                serve(exp_trap(v[7:5]));
                do_poll(seen);
                chk("R8 no pulse after service", seen, 0);
            end
        end

        // R5 busy bus blocks control; R2 poll suppressed during request; R10 event on clear edge
        lvl_sel = 2'd2;
        post(3'd4, 1'b1, 1'b0);
        do_poll(seen);
        ien_n = 1'b0;
        bus_busy_in = 1'b1;
        tick();
        tick();
        chk("R5 busy bus blocks control", bus_busy_out, 0);
        chk("R5 no trap while blocked", trap_addr, 0);
        chk("R4 chain held broken", grant_out, 0);
        post(3'd6, 1'b1, 1'b0);
        do_poll(seen);
        chk("R2 poll ignored during request", seen, 0);
        bus_busy_in = 1'b0;
        tick();
        chk("R5 control after bus frees", bus_busy_out, 1);
        chk("R11 first source kept", trap_addr, exp_trap(3'd4));
        post(3'd2, 1'b1, 1'b0);
        chk("R6 iadv low", iadv_n, 0);
        chk("R10 trap unchanged by new event", trap_addr, exp_trap(3'd4));
        ien_n = 1'b1;
        tick();
        chk("R7 teardown", bus_busy_out, 0);
        do_poll(seen);
        chk("R10 new event posted at next poll", seen, 3'b100);
        serve(exp_trap(3'd2));

        // R11 two events before poll
        lvl_sel = 2'd0;
        post(3'd1, 1'b1, 1'b0);
        post(3'd6, 1'b1, 1'b0);
        do_poll(seen);
        chk("R11 level for first event", seen, 3'b001);
        serve(exp_trap(3'd1));

        // R7 abandoned request leaves interrupt posted
        lvl_sel = 2'd1;
        post(3'd3, 1'b1, 1'b0);
        do_poll(seen);
        ien_n = 1'b0;
        tick();
        chk("R4 request breaks chain", grant_out, 0);
        ien_n = 1'b1;
        tick();
        chk("R7 abandon restores chain", grant_out, 1);
        chk("R7 no control after abandon", bus_busy_out, 0);
        do_poll(seen);
        chk("R7 repoll after abandon", seen, 3'b010);
        serve(exp_trap(3'd3));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule